// File: doc/BRIEF.md
# Posted Write Byte-Merge Buffer

This block sits in the posted memory write path of a bridge and holds one 32-bit word of write data at a time. Upstream writes arrive with a word address, four byte lanes of data, a byte-enable mask and a flag that says whether the target region is prefetchable. Partial writes to the same word are combined in the buffer. The bytes may arrive in any order, provided each lane is written only once. The combined word is later sent downstream as one write carrying the union of the enables.

Some writes cannot be combined: a write to another word, a write that touches a lane already held, or a write to a non-prefetchable region. Each of these first pushes the held word out. A non-prefetchable write is never held; it goes downstream on its own once the buffer is empty. The held word also leaves on an explicit flush request, or after a programmable number of cycles with no accepted write. The downstream side is a registered valid/ready port. When a flush is needed but the output register is still occupied and stalled, the upstream ready is withdrawn.

Top module: `wmerge_buf`

## Requirements
- R1: During and directly after reset, no downstream write is offered (dn_valid = 0), nothing is held, and a write can be accepted (up_ready = 1).
- R2: Prefetchable writes to the held word whose enables do not overlap the held enables are merged. The later downstream write carries the OR of all merged enables, and only one write is produced.
- R3: For every lane i (lane i is data bits 8i+7..8i, enable bit i), the downstream byte comes from the merged write whose enable bit i was set. Lanes whose enable is 0 go out as 0x00.
- R4: A prefetchable write to the held word that sets an already-held enable bit first sends the held word out unchanged. The new write then becomes the held word by itself.
- R5: A prefetchable write to a different word address first sends the held word out. The new write then becomes the held word.
- R6: A write with up_pref = 0 is forwarded downstream alone with its own address, enables and masked data, and is never held. If a word is held, that word goes out first.
- R7: While dn_valid = 1 and dn_ready = 0, dn_valid, dn_word_addr, dn_data and dn_be stay unchanged.
- R8: up_ready is 0 while the held word must be sent out to accept the offered write and the output register is stalled. A mergeable write is still accepted during such a stall.
- R9: A one-cycle flush_req sends the held word downstream; with nothing held it produces no write.
- R10: A held word with no accepted write for IDLE_LIMIT cycles after the cycle it was written is offered downstream one cycle later. Counting from the accepting clock edge, dn_valid rises after edge IDLE_LIMIT+1.
- R11: Each merge restarts the idle count of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream write request present |
| up_ready | output | 1 | Upstream write accepted this cycle when up_valid is also high |
| up_word_addr | input | WORD_W | 32-bit word address of the write |
| up_data | input | LANES*8 | Write data, lane i in bits 8i+7..8i |
| up_be | input | LANES | Byte enables, bit i for lane i |
| up_pref | input | 1 | Target region is prefetchable (merging allowed) |
| flush_req | input | 1 | Send the held word downstream |
| dn_valid | output | 1 | Downstream write offered |
| dn_ready | input | 1 | Downstream accepts the offered write |
| dn_word_addr | output | WORD_W | Word address of the downstream write |
| dn_data | output | LANES*8 | Downstream data, disabled lanes zero |
| dn_be | output | LANES | Downstream byte enables |

## Verification
up_ready depends combinationally on the held state and on dn_ready, so it is read half a cycle after the inputs change. A write offered on a falling edge is accepted on the next rising edge. A write that causes a flush makes the held word appear on dn_valid right after that same rising edge, and a flush_req behaves the same way. The timeout result is due after rising edge IDLE_LIMIT+1, counted from the accepting edge. The bench samples dn_valid on the falling edges on either side of that point. A monitor logs each downstream handshake on the falling edge before the rising edge that completes it, and the per-scenario tasks compare the log order and contents once the expected number of cycles has passed.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic drain;
    logic load;
    logic merge;
    logic fwd;
  } wbm_act_t;
endpackage

// File: rtl/wbm_decide.sv
module wbm_decide
  import wbm_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int LANES  = 4
) (
  input  logic              entry_v,
  input  logic [WORD_W-1:0] entry_word,
  input  logic [LANES-1:0]  entry_be,
  input  logic              up_valid,
  input  logic              up_pref,
  input  logic [WORD_W-1:0] up_word,
  input  logic [LANES-1:0]  up_be,
  input  logic              slot_free,
  input  logic              flush_req,
  input  logic              tmo,
  output logic              up_ready,
  output logic              conflict,
  output wbm_act_t          act
);
  logic accept;

  always_comb begin
    conflict = entry_v && (!up_pref || (up_word != entry_word) || ((entry_be & up_be) != '0));
    if (up_pref) up_ready = !conflict || slot_free;
    else         up_ready = !entry_v && slot_free;
    accept    = up_valid && up_ready;
    act.drain = entry_v && slot_free && (flush_req || tmo || (up_valid && conflict));
    act.fwd   = accept && !up_pref;
    act.load  = accept && up_pref && (!entry_v || act.drain);
    act.merge = accept && up_pref && entry_v && !act.drain;
  end
endmodule

// File: rtl/wbm_lane_merge.sv
module wbm_lane_merge
  import wbm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*BYTE_W-1:0] old_data,
  input  logic [LANES-1:0]        old_be,
  input  logic [LANES*BYTE_W-1:0] new_data,
  input  logic [LANES-1:0]        new_be,
  input  logic                    fresh,
  output logic [LANES*BYTE_W-1:0] out_data,
  output logic [LANES-1:0]        out_be
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      if (new_be[i])  out_data[i*BYTE_W +: BYTE_W] = new_data[i*BYTE_W +: BYTE_W];
      else if (fresh) out_data[i*BYTE_W +: BYTE_W] = '0;
      else            out_data[i*BYTE_W +: BYTE_W] = old_data[i*BYTE_W +: BYTE_W];
      out_be[i] = new_be[i] || (!fresh && old_be[i]);
    end
  end
endmodule

// File: rtl/wbm_idle_timer.sv
module wbm_idle_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic entry_v,
  input  logic accept,
  input  logic drain,
  output logic tmo
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || accept || drain || !entry_v) cnt <= '0;
    else if (cnt != LIM)                    cnt <= cnt + 1'b1;
  end

  assign tmo = entry_v && (cnt == LIM);

  assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
    accept |=> !tmo);
endmodule

// File: rtl/wmerge_buf.sv
module wmerge_buf
  import wbm_pkg::*;
#(
  parameter int WORD_W     = 30,
  parameter int LANES      = 4,
  parameter int IDLE_LIMIT = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    up_valid,
  output logic                    up_ready,
  input  logic [WORD_W-1:0]       up_word_addr,
  input  logic [LANES*BYTE_W-1:0] up_data,
  input  logic [LANES-1:0]        up_be,
  input  logic                    up_pref,
  input  logic                    flush_req,
  output logic                    dn_valid,
  input  logic                    dn_ready,
  output logic [WORD_W-1:0]       dn_word_addr,
  output logic [LANES*BYTE_W-1:0] dn_data,
  output logic [LANES-1:0]        dn_be
);
  localparam int DATA_W = LANES * BYTE_W;

  logic              entry_v;
  logic [WORD_W-1:0] entry_word;
  logic [DATA_W-1:0] entry_data;
  logic [LANES-1:0]  entry_be;
  logic              slot_free, tmo, conflict, fresh;
  wbm_act_t          act;
  logic [DATA_W-1:0] mrg_data, fwd_data;
  logic [LANES-1:0]  mrg_be, fwd_be;

  assign slot_free = !dn_valid || dn_ready;
  assign fresh     = !entry_v || act.drain;

  wbm_decide #(.WORD_W(WORD_W), .LANES(LANES)) u_decide (
    .entry_v(entry_v), .entry_word(entry_word), .entry_be(entry_be),
    .up_valid(up_valid), .up_pref(up_pref), .up_word(up_word_addr), .up_be(up_be),
    .slot_free(slot_free), .flush_req(flush_req), .tmo(tmo),
    .up_ready(up_ready), .conflict(conflict), .act(act)
  );

  wbm_lane_merge #(.LANES(LANES)) u_merge (
    .old_data(entry_data), .old_be(entry_be), .new_data(up_data), .new_be(up_be),
    .fresh(fresh), .out_data(mrg_data), .out_be(mrg_be)
  );

  wbm_lane_merge #(.LANES(LANES)) u_mask (
    .old_data(entry_data), .old_be(entry_be), .new_data(up_data), .new_be(up_be),
    .fresh(1'b1), .out_data(fwd_data), .out_be(fwd_be)
  );

  wbm_idle_timer #(.LIMIT(IDLE_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .entry_v(entry_v),
    .accept(act.load || act.merge), .drain(act.drain), .tmo(tmo)
  );

  // held word
  always_ff @(posedge clk) begin
    if (rst) begin
      entry_v    <= 1'b0;
      entry_word <= '0;
      entry_data <= '0;
      entry_be   <= '0;
    end else begin
      if (act.load || act.merge) begin
        entry_v    <= 1'b1;
        entry_data <= mrg_data;
        entry_be   <= mrg_be;
        if (act.load) entry_word <= up_word_addr;
      end else if (act.drain) begin
        entry_v <= 1'b0;
      end
    end
  end

  // registered downstream slot
  always_ff @(posedge clk) begin
    if (rst) begin
      dn_valid     <= 1'b0;
      dn_word_addr <= '0;
      dn_data      <= '0;
      dn_be        <= '0;
    end else if (act.drain) begin
      dn_valid     <= 1'b1;
      dn_word_addr <= entry_word;
      dn_data      <= entry_data;
      dn_be        <= entry_be;
    end else if (act.fwd) begin
      dn_valid     <= 1'b1;
      dn_word_addr <= up_word_addr;
      dn_data      <= fwd_data;
      dn_be        <= fwd_be;
    end else if (dn_ready) begin
      dn_valid     <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!dn_valid && !entry_v));

  assert_hold_out_R7: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_word_addr) && $stable(dn_data) && $stable(dn_be)));

  assert_union_be_R2: assert property (@(posedge clk) disable iff (rst)
    act.merge |=> (entry_v && entry_be == ($past(entry_be) | $past(up_be))));

  assert_overlap_flush_R4: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready && up_pref && entry_v && up_word_addr == entry_word && (entry_be & up_be) != '0)
      |=> (dn_valid && dn_be == $past(entry_be) && entry_be == $past(up_be)));

  assert_addr_flush_R5: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready && up_pref && entry_v && up_word_addr != entry_word)
      |=> (dn_valid && dn_word_addr == $past(entry_word) && entry_word == $past(up_word_addr)));

  assert_fwd_alone_R6: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_ready && !up_pref)
      |=> (dn_valid && !entry_v && dn_be == $past(up_be) && dn_word_addr == $past(up_word_addr)));

  assert_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (up_valid && entry_v && dn_valid && !dn_ready && up_word_addr != entry_word) |-> !up_ready);

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_zero_lane_R3: assert property (@(posedge clk) disable iff (rst)
      (dn_valid && !dn_be[i]) |-> (dn_data[i*BYTE_W +: BYTE_W] == '0));
  end
endmodule

// File: tb/wmerge_buf_tb.sv
module wmerge_buf_tb_top;
  localparam int LIM = 5;

  logic        clk = 1'b0;
  logic        rst;
  logic        up_valid, up_ready, up_pref, flush_req;
  logic [29:0] up_word_addr;
  logic [31:0] up_data;
  logic [3:0]  up_be;
  logic        dn_valid, dn_ready;
  logic [29:0] dn_word_addr;
  logic [31:0] dn_data;
  logic [3:0]  dn_be;

  int n_chk = 0;
  int n_fail = 0;

  logic [29:0] log_a [32];
  logic [31:0] log_d [32];
  logic [3:0]  log_b [32];
  int log_n = 0;

  always #5 clk = ~clk;

  wmerge_buf #(.WORD_W(30), .LANES(4), .IDLE_LIMIT(LIM)) dut_i (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_word_addr(up_word_addr), .up_data(up_data), .up_be(up_be), .up_pref(up_pref),
    .flush_req(flush_req), .dn_valid(dn_valid), .dn_ready(dn_ready),
    .dn_word_addr(dn_word_addr), .dn_data(dn_data), .dn_be(dn_be)
  );

  // handshake monitor: sampled just after the falling edge
  always @(negedge clk) begin
    #1;
    if (!rst && dn_valid && dn_ready && log_n < 32) begin
      log_a[log_n] = dn_word_addr;
      log_d[log_n] = dn_data;
      log_b[log_n] = dn_be;
      log_n++;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_log(input string req, input int idx, input logic [29:0] a,
                           input logic [31:0] d, input logic [3:0] b);
    check({req, " addr"}, 32'(log_a[idx]), 32'(a));
    check({req, " data"}, log_d[idx], d);
    check({req, " be"},   32'(log_b[idx]), 32'(b));
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wr(input logic [29:0] a, input logic [31:0] d, input logic [3:0] b, input logic p);
    up_valid = 1'b1; up_word_addr = a; up_data = d; up_be = b; up_pref = p;
    #1;
    while (!up_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic flush;
    flush_req = 1'b1;
    @(negedge clk);
    flush_req = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic settle;
    repeat (3) @(negedge clk);
    log_n = 0;
  endtask

  task automatic t_reset;
    #1;
    check("R1 dn_valid after reset", 32'(dn_valid), 32'd0);
    check("R1 up_ready after reset", 32'(up_ready), 32'd1);
    flush();
    check("R1 nothing held at reset", 32'(log_n), 32'd0);
  endtask

  task automatic t_merge_any_order;
    settle();
    wr(30'h40, 32'h000000A0, 4'b0001, 1'b1);
    wr(30'h40, 32'h00C20000, 4'b0100, 1'b1);
    wr(30'h40, 32'h0000B100, 4'b0010, 1'b1);
    wr(30'h40, 32'hD3000000, 4'b1000, 1'b1);
    check("R2 no write before flush", 32'(log_n), 32'd0);
    flush();
    check("R9 flush gives one write", 32'(log_n), 32'd1);
    check_log("R2 merged word", 0, 30'h40, 32'hD3C2B1A0, 4'hF);
    flush();
    check("R9 empty flush no write", 32'(log_n), 32'd1);
  endtask

  task automatic t_lane_select;
    settle();
    wr(30'h41, 32'h11223344, 4'b0001, 1'b1);
    wr(30'h41, 32'h55667788, 4'b1000, 1'b1);
    flush();
    check("R3 lane select count", 32'(log_n), 32'd1);
    check_log("R3 lane select", 0, 30'h41, 32'h55000044, 4'b1001);
  endtask

  task automatic t_overlap;
    settle();
    wr(30'h50, 32'h0000AABB, 4'b0011, 1'b1);
    wr(30'h50, 32'h0000CC00, 4'b0010, 1'b1);
    repeat (2) @(negedge clk);
    check("R4 old word out first", 32'(log_n), 32'd1);
    check_log("R4 first write", 0, 30'h50, 32'h0000AABB, 4'b0011);
    flush();
    check("R4 second count", 32'(log_n), 32'd2);
    check_log("R4 new write alone", 1, 30'h50, 32'h0000CC00, 4'b0010);
  endtask

  task automatic t_addr_change;
    settle();
    wr(30'h60, 32'h000000E1, 4'b0001, 1'b1);
    wr(30'h61, 32'h0000E200, 4'b0010, 1'b1);
    repeat (2) @(negedge clk);
    check("R5 flush on new word", 32'(log_n), 32'd1);
    check_log("R5 first word", 0, 30'h60, 32'h000000E1, 4'b0001);
    flush();
    check_log("R5 second word", 1, 30'h61, 32'h0000E200, 4'b0010);
  endtask

  task automatic t_nonpref;
    settle();
    wr(30'h70, 32'h12345678, 4'b0110, 1'b0);
    repeat (2) @(negedge clk);
    check("R6 forwarded alone count", 32'(log_n), 32'd1);
    check_log("R6 forwarded", 0, 30'h70, 32'h00345600, 4'b0110);
    flush();
    check("R6 not held", 32'(log_n), 32'd1);
    settle();
    wr(30'h71, 32'h000000F1, 4'b0001, 1'b1);
    wr(30'h71, 32'h0000F200, 4'b0010, 1'b0);
    repeat (2) @(negedge clk);
    check("R6 held then forward count", 32'(log_n), 32'd2);
    check_log("R6 held first", 0, 30'h71, 32'h000000F1, 4'b0001);
    check_log("R6 forward second", 1, 30'h71, 32'h0000F200, 4'b0010);
  endtask

  task automatic t_stall;
    settle();
    dn_ready = 1'b0;
    wr(30'h80, 32'h000000A1, 4'b0001, 1'b1);
    wr(30'h81, 32'h0000B200, 4'b0010, 1'b1);
    wr(30'h81, 32'h00C30000, 4'b0100, 1'b1);
    check("R8 merge accepted during stall", 32'(dn_data), 32'h000000A1);
    up_valid = 1'b1; up_word_addr = 30'h82; up_data = 32'h000000D4; up_be = 4'b0001; up_pref = 1'b1;
    #1;
    check("R8 ready low on stall", 32'(up_ready), 32'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R8 ready still low", 32'(up_ready), 32'd0);
    check("R7 valid held", 32'(dn_valid), 32'd1);
    check("R7 data held", dn_data, 32'h000000A1);
    check("R7 addr held", 32'(dn_word_addr), 32'h80);
    @(negedge clk);
    dn_ready = 1'b1;
    #1;
    check("R8 ready after release", 32'(up_ready), 32'd1);
    @(negedge clk);
    up_valid = 1'b0;
    flush();
    check("R8 stall sequence count", 32'(log_n), 32'd3);
    check_log("R7 stalled write", 0, 30'h80, 32'h000000A1, 4'b0001);
    check_log("R8 merged during stall", 1, 30'h81, 32'h00C3B200, 4'b0110);
    check_log("R8 held write", 2, 30'h82, 32'h000000D4, 4'b0001);
  endtask

  task automatic t_timeout;
    settle();
    wr(30'h90, 32'h000000EE, 4'b0001, 1'b1);
    repeat (LIM) @(negedge clk);
    #1;
    check("R10 not yet out", 32'(dn_valid), 32'd0);
    @(negedge clk);
    #1;
    check("R10 out after limit", 32'(dn_valid), 32'd1);
    check("R10 data", dn_data, 32'h000000EE);
    settle();
    wr(30'h91, 32'h00000011, 4'b0001, 1'b1);
    repeat (LIM - 1) @(negedge clk);
    wr(30'h91, 32'h00002200, 4'b0010, 1'b1);
    repeat (LIM) @(negedge clk);
    #1;
    check("R11 count restarted", 32'(dn_valid), 32'd0);
    @(negedge clk);
    #1;
    check("R11 out after restart", 32'(dn_valid), 32'd1);
    check("R11 merged data", dn_data, 32'h00002211);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; up_valid = 1'b0; up_word_addr = '0; up_data = '0; up_be = '0;
    up_pref = 1'b0; flush_req = 1'b0; dn_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 dn_valid in reset", 32'(dn_valid), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_merge_any_order();
    t_lane_select();
    t_overlap();
    t_addr_change();
    t_nonpref();
    t_stall();
    t_timeout();
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule